// File: doc/BRIEF.md
# Separable Six-Tap Quarter-Sample Luma Interpolator

This block turns a square window of 8-bit reference luma pixels into a 16x16 block of quarter-sample predictions. The window arrives one row per handshake beat, 21 pixels wide and 21 rows tall for the default size. A six-tap vertical filter runs first. It keeps the sums unrounded at 16 signed bits. A six-tap horizontal filter then runs over those sums. It rounds and shifts once, by 10 bits, and saturates each result to an 8-bit half-sample value. The horizontal pass yields 17 half-sample values per row. Each pair of horizontally adjacent half-sample values is then averaged with upward rounding, which gives 16 quarter-sample pixels per output row.

A controller starts one block per start pulse. Output rows leave through a valid/ready port. Output backpressure stalls the whole pipeline, so no data is lost. A one-cycle done pulse marks the end of the block.

Top module: `subpel_interp`

## Requirements
- R1: Intermediate value (r, c), for r = 0..15 and c = 0..20, is the sum over t = 0..5 of w[t]·p[r+t][c], where w = {1, -5, 20, 20, -5, 1} and p[row][col] is an input pixel. It is kept unrounded as a 16-bit signed value.
- R2: Half-sample value k of a row is h = (the sum over t of w[t]·m[k+t] + 512) >> 10, using an arithmetic shift. The sum is taken in an accumulator of at least 20 signed bits. The result is then clipped to the range 0..255.
- R3: Each row has 17 half-sample values, k = 0..16. An intermediate column index above 20 is clamped to 20, so value 16 reuses the last column for its final tap.
- R4: Output pixel c of a row is (h[c] + h[c+1] + 1) >> 1. Pixel c occupies bits [8c+7:8c] of out_row, and input pixel c occupies bits [8c+7:8c] of in_row.
- R5: A row is taken only on a cycle where in_valid and in_ready are both high. in_ready is low while the block is idle, and it stays low once all 21 rows of the current block have been taken.
- R6: A start pulse while idle begins a new block. A start pulse while a block is in progress has no effect.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_row holds its value. Every row reaches the output in order.
- R8: done is high for exactly one cycle, in the cycle after the 16th output row is accepted. After that cycle the block is idle.
- R9: A synchronous active-high reset leaves in_ready, out_valid and done low.
- R10: Output row r depends on input rows r..r+5 only. Exactly 16 output rows are produced per block, and out_valid stays low while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a block when the block is idle |
| in_valid | input | 1 | An input row is presented |
| in_ready | output | 1 | The block can take an input row |
| in_row | input | 168 | One row of 21 reference pixels, 8 bits each |
| out_valid | output | 1 | An output row is presented |
| out_ready | input | 1 | The consumer takes the output row |
| out_row | output | 128 | One row of 16 quarter-sample pixels, 8 bits each |
| done | output | 1 | One-cycle pulse after the last output row |

## Verification
The bench builds the block with its default parameters: a 16x16 output, 8-bit pixels, a 16-bit intermediate and a 20-bit accumulator. With these values the right-edge column clamp is reached on every row. Stripe windows drive the horizontal sums far past both clip rails, close to the accumulator's extremes. Random and long-stall output backpressure exercise the shared stall, and a start pulse issued in the middle of a block exercises the busy guard.

// File: rtl/subpel_pkg.sv
package subpel_pkg;
  // Six-tap half-sample kernel shared by both passes
  localparam int TAP_N = 6;
  localparam int TAP_COEF [TAP_N] = '{1, -5, 20, 20, -5, 1};
  // Rounding applied once, after the second pass
  localparam int ROUND_SH  = 10;
  localparam int ROUND_ADD = 1 << (ROUND_SH - 1);
endpackage

// File: rtl/subpel_vfilt.sv
module subpel_vfilt
  import subpel_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int MID_W = 16,
  parameter int COLS  = 21
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift_en,
  input  logic                   emit_en,
  input  logic [COLS*PIX_W-1:0]  row_in,
  output logic [COLS*MID_W-1:0]  mid_row
);
  localparam int HIST = TAP_N - 1;

  // hist[0] is the newest stored row, hist[HIST-1] the oldest
  logic [COLS*PIX_W-1:0] hist [HIST];
  logic [COLS*PIX_W-1:0] src  [TAP_N];
  logic [COLS*MID_W-1:0] mid_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HIST; i++) hist[i] <= '0;
    end else if (shift_en) begin
      hist[0] <= row_in;
      for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
    end
  end

  // Tap 0 is the oldest row and the last tap is the incoming row
  always_comb begin
    src[TAP_N-1] = row_in;
    for (int t = 0; t < HIST; t++) src[t] = hist[HIST-1-t];
  end

  function automatic logic [MID_W-1:0] vtap(input logic [TAP_N*PIX_W-1:0] s);
    int acc;
    acc = 0;
    for (int t = 0; t < TAP_N; t++)
      acc = acc + TAP_COEF[t] * int'(s[t*PIX_W +: PIX_W]);
    return MID_W'(acc);
  endfunction

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [TAP_N*PIX_W-1:0] colv;
    for (genvar t = 0; t < TAP_N; t++) begin : g_tap
      assign colv[t*PIX_W +: PIX_W] = src[t][c*PIX_W +: PIX_W];
    end
    assign mid_next[c*MID_W +: MID_W] = vtap(colv);
  end

  always_ff @(posedge clk) begin
    if (rst)          mid_row <= '0;
    else if (emit_en) mid_row <= mid_next;
  end
endmodule

// File: rtl/subpel_hfilt.sv
module subpel_hfilt
  import subpel_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int MID_W  = 16,
  parameter int ACC_W  = 20,
  parameter int COLS   = 21,
  parameter int HALF_N = 17
) (
  input  logic [COLS*MID_W-1:0]   mid_row,
  output logic [HALF_N*PIX_W-1:0] half_row
);
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  function automatic logic [PIX_W-1:0] htap(input logic [TAP_N*MID_W-1:0] s);
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] sh;
    acc = '0;
    for (int t = 0; t < TAP_N; t++)
      acc = acc + ACC_W'(TAP_COEF[t]) * ACC_W'($signed(s[t*MID_W +: MID_W]));
    acc = acc + ACC_W'(ROUND_ADD);
    sh  = acc >>> ROUND_SH;
    if (sh[ACC_W-1])                  return '0;
    else if (sh > ACC_W'(PIX_MAX))    return PIX_W'(PIX_MAX);
    else                              return sh[PIX_W-1:0];
  endfunction

  for (genvar k = 0; k < HALF_N; k++) begin : g_half
    logic [TAP_N*MID_W-1:0] samp;
    for (genvar t = 0; t < TAP_N; t++) begin : g_tap
      // Columns past the right edge reuse the last intermediate column
      localparam int SRC = (k + t > COLS - 1) ? COLS - 1 : k + t;
      assign samp[t*MID_W +: MID_W] = mid_row[SRC*MID_W +: MID_W];
    end
    assign half_row[k*PIX_W +: PIX_W] = htap(samp);
  end
endmodule

// File: rtl/subpel_qavg.sv
module subpel_qavg #(
  parameter int PIX_W = 8,
  parameter int OUT_W = 16
) (
  input  logic [(OUT_W+1)*PIX_W-1:0] half_row,
  output logic [OUT_W*PIX_W-1:0]     q_row
);
  for (genvar c = 0; c < OUT_W; c++) begin : g_avg
    logic [PIX_W:0] pair_sum;
    assign pair_sum = {1'b0, half_row[c*PIX_W +: PIX_W]}
                    + {1'b0, half_row[(c+1)*PIX_W +: PIX_W]}
                    + (PIX_W+1)'(1);
    assign q_row[c*PIX_W +: PIX_W] = pair_sum[PIX_W:1];
  end
endmodule

// File: rtl/subpel_interp.sv
module subpel_interp
  import subpel_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int OUT_W = 16,
  parameter int OUT_H = 16,
  parameter int MID_W = 16,
  parameter int ACC_W = 20
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic [(OUT_W+TAP_N-1)*PIX_W-1:0]   in_row,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [OUT_W*PIX_W-1:0]             out_row,
  output logic                               done
);
  localparam int WIN_W  = OUT_W + TAP_N - 1;
  localparam int WIN_H  = OUT_H + TAP_N - 1;
  localparam int HALF_N = OUT_W + 1;
  localparam int PRIME  = TAP_N - 1;
  localparam int ICNT_W = $clog2(WIN_H + 1);
  localparam int OCNT_W = $clog2(OUT_H + 1);

  logic              busy;
  logic [ICNT_W-1:0] in_cnt;
  logic [OCNT_W-1:0] out_cnt;
  logic              v_valid;
  logic              out_load, v_adv, in_fire, emit, out_fire, last_out;

  logic [WIN_W*MID_W-1:0]   mid_row;
  logic [HALF_N*PIX_W-1:0]  half_row;
  logic [OUT_W*PIX_W-1:0]   q_row;

  // One stall chain: output register, then intermediate register, then input
  assign out_load = !out_valid || out_ready;
  assign v_adv    = !v_valid || out_load;
  assign in_ready = busy && (in_cnt < ICNT_W'(WIN_H)) && v_adv;
  assign in_fire  = in_valid && in_ready;
  assign emit     = in_fire && (in_cnt >= ICNT_W'(PRIME));
  assign out_fire = out_valid && out_ready;
  assign last_out = out_fire && (out_cnt == OCNT_W'(OUT_H - 1));

  subpel_vfilt #(
    .PIX_W(PIX_W), .MID_W(MID_W), .COLS(WIN_W)
  ) u_vfilt (
    .clk(clk), .rst(rst), .shift_en(in_fire), .emit_en(emit),
    .row_in(in_row), .mid_row(mid_row)
  );

  subpel_hfilt #(
    .PIX_W(PIX_W), .MID_W(MID_W), .ACC_W(ACC_W), .COLS(WIN_W), .HALF_N(HALF_N)
  ) u_hfilt (
    .mid_row(mid_row), .half_row(half_row)
  );

  subpel_qavg #(
    .PIX_W(PIX_W), .OUT_W(OUT_W)
  ) u_qavg (
    .half_row(half_row), .q_row(q_row)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      in_cnt    <= '0;
      out_cnt   <= '0;
      v_valid   <= 1'b0;
      out_valid <= 1'b0;
      out_row   <= '0;
      done      <= 1'b0;
    end else begin
      done <= last_out;
      if (start && !busy) begin
        busy    <= 1'b1;
        in_cnt  <= '0;
        out_cnt <= '0;
      end else begin
        if (in_fire)  in_cnt  <= in_cnt + 1'b1;
        if (out_fire) out_cnt <= last_out ? '0 : out_cnt + 1'b1;
        if (last_out) busy    <= 1'b0;
      end
      if (v_adv) v_valid <= emit;
      if (out_load) begin
        out_valid <= v_valid;
        if (v_valid) out_row <= q_row;
      end
    end
  end
endmodule

// File: rtl/subpel_interp_chk.sv
module subpel_interp_chk #(
  parameter int PIX_W = 8,
  parameter int OUT_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   busy,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [OUT_W*PIX_W-1:0] out_row,
  input logic                   done
);
  assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_row)));

  assert_no_ready_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !in_ready);

  assert_done_follows_accept_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid && out_ready));

  assert_done_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idle_at_done_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_no_output_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !out_valid);
endmodule

bind subpel_interp subpel_interp_chk #(.PIX_W(PIX_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/subpel_interp_bench.sv
module subpel_interp_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 8;
  localparam int OUT_W = 16;
  localparam int OUT_H = 16;
  localparam int TAPS  = 6;
  localparam int WIN_W = OUT_W + TAPS - 1;
  localparam int WIN_H = OUT_H + TAPS - 1;
  localparam int COEF [TAPS] = '{1, -5, 20, 20, -5, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [WIN_W*PIX_W-1:0] in_row = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [OUT_W*PIX_W-1:0] out_row;
  logic done;

  int checks = 0;
  int errors = 0;
  int win  [WIN_H][WIN_W];
  int mid  [OUT_H][WIN_W];
  int half [OUT_H][OUT_W+1];
  int expq [OUT_H][OUT_W];

  always #(CLK_PERIOD/2) clk = ~clk;

  subpel_interp u_subpel_interp (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .out_valid(out_valid), .out_ready(out_ready),
    .out_row(out_row), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Model of R1..R4 over the current window
  task automatic compute_expected();
    for (int r = 0; r < OUT_H; r++) begin
      for (int c = 0; c < WIN_W; c++) begin
        int s = 0;
        for (int t = 0; t < TAPS; t++) s += COEF[t] * win[r+t][c];
        mid[r][c] = s;
      end
      for (int k = 0; k <= OUT_W; k++) begin
        int s = 0;
        for (int t = 0; t < TAPS; t++) begin
          int idx = (k + t > WIN_W - 1) ? WIN_W - 1 : k + t;
          s += COEF[t] * mid[r][idx];
        end
        s = (s + 512) >>> 10;
        half[r][k] = (s < 0) ? 0 : (s > 255) ? 255 : s;
      end
      for (int c = 0; c < OUT_W; c++)
        expq[r][c] = (half[r][c] + half[r][c+1] + 1) >> 1;
    end
  endtask

  function automatic logic [WIN_W*PIX_W-1:0] pack_in(input int r);
    logic [WIN_W*PIX_W-1:0] v;
    for (int c = 0; c < WIN_W; c++) v[c*PIX_W +: PIX_W] = 8'(win[r][c]);
    return v;
  endfunction

  function automatic logic [OUT_W*PIX_W-1:0] pack_exp(input int r);
    logic [OUT_W*PIX_W-1:0] v;
    for (int c = 0; c < OUT_W; c++) v[c*PIX_W +: PIX_W] = 8'(expq[r][c]);
    return v;
  endfunction

  task automatic drive_rows();
    int r = 0;
    while (r < WIN_H) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_row   = pack_in(r);
      #1;
      if (in_ready) r++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(in_ready == 1'b0, "R5", "in_ready after last input row", 256'(in_ready), 256'(0));
  endtask

  // mode 0: always ready, 1: random ready, 2: long stalls
  task automatic collect_rows(input int mode, input string tag);
    int k = 0;
    int cyc = 0;
    while (k < OUT_H) begin
      @(negedge clk);
      case (mode)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom % 3) != 0;
        default: out_ready = (cyc % 5) == 4;
      endcase
      cyc++;
      #1;
      if (out_valid && out_ready) begin
        check(out_row == pack_exp(k), tag, $sformatf("output row %0d", k),
              256'(out_row), 256'(pack_exp(k)));
        k++;
      end
    end
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    check(done == 1'b1, "R8", "done after last accepted row", 256'(done), 256'(1));
    @(negedge clk);
    #1;
    check(done == 1'b0, "R8", "done lasts one cycle", 256'(done), 256'(0));
    check(out_valid == 1'b0, "R10", "no extra output row", 256'(out_valid), 256'(0));
    check(in_ready == 1'b0, "R5", "in_ready low when idle", 256'(in_ready), 256'(0));
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_block(input int mode, input bit mid_start, input string tag);
    compute_expected();
    pulse_start();
    fork
      drive_rows();
      collect_rows(mode, tag);
      begin
        if (mid_start) begin
          repeat (12) @(negedge clk);
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(in_ready == 1'b0 && out_valid == 1'b0 && done == 1'b0, "R9",
          "outputs during reset", 256'({in_ready, out_valid, done}), 256'(0));
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(in_ready == 1'b0, "R5", "idle without start", 256'(in_ready), 256'(0));
  endtask

  task automatic test_ramp();
    for (int r = 0; r < WIN_H; r++)
      for (int c = 0; c < WIN_W; c++) win[r][c] = (r * 7 + c * 11) % 256;
    run_block(0, 1'b0, "R1/R2/R3/R4/R10 ramp");
  endtask

  task automatic test_stripes(input bit invert);
    for (int r = 0; r < WIN_H; r++)
      for (int c = 0; c < WIN_W; c++) begin
        bit hot = ((r % 6) != 1 && (r % 6) != 4) && ((c % 6) != 1 && (c % 6) != 4);
        win[r][c] = (hot ^ invert) ? 255 : 0;
      end
    run_block(0, 1'b0, invert ? "R2 clip low" : "R2 clip high");
  endtask

  task automatic test_edge_column();
    for (int r = 0; r < WIN_H; r++)
      for (int c = 0; c < WIN_W; c++) win[r][c] = (c == WIN_W - 1) ? 250 : 10 + r;
    run_block(0, 1'b0, "R3 right edge clamp");
  endtask

  task automatic test_random_backpressure();
    for (int r = 0; r < WIN_H; r++)
      for (int c = 0; c < WIN_W; c++) win[r][c] = $urandom % 256;
    run_block(1, 1'b0, "R7 random stall");
  endtask

  task automatic test_long_stall();
    for (int r = 0; r < WIN_H; r++)
      for (int c = 0; c < WIN_W; c++) win[r][c] = $urandom % 256;
    run_block(2, 1'b0, "R7 long stall");
  endtask

  task automatic test_start_ignored();
    for (int r = 0; r < WIN_H; r++)
      for (int c = 0; c < WIN_W; c++) win[r][c] = (r * 31 + c * c) % 256;
    run_block(1, 1'b1, "R6 start while busy");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(13));
    test_reset();
    test_ramp();
    test_stripes(1'b0);
    test_stripes(1'b1);
    test_edge_column();
    test_random_backpressure();
    test_long_stall();
    test_start_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule